// File: doc/BRIEF.md
# Wake-up pattern CRC matcher

This block watches a received frame as a byte stream while the device sleeps and signals a wake event when one of eight programmed patterns is found. Each pattern is defined by a length, a per-byte enable mask and an expected CRC-32. Each pattern has its own CRC lane. The lane sees the incoming byte where that pattern's enable bit is set and sees 0x00 where it is clear. At the end of the frame, the lane's complemented CRC is compared with the stored value.

All eight lanes advance in the same cycle, one byte per valid beat, over the first 128 bytes of the frame. A match is only reported if the global enable is on. It raises a sticky wake flag together with the index of the lowest matching slot. Software clears the flag by writing the control register. It must keep the global enable off while no pattern is programmed.

Top module: `wake_crc_matcher`

## Requirements
- R1: After reset, wake_o is 0, wake_idx_o is 0, the global enable is off, every slot length is 0 and every byte-enable bit is 0.
- R2: The write port uses word address wr_addr_i with the following map. Addresses 0 to 15 write byte-enable word w from all 64 bits. Addresses 16+p write the length of slot p from bits 7:0. Addresses 24+p write the expected CRC of slot p from bits 31:0. Address 32 writes the global enable from bit 0.
- R3: Byte-enable word w covers frame bytes 8w to 8w+7. The enable for byte offset b (0 to 7) of slot p is bit (7-b)*8+p.
- R4: The CRC lane of slot p starts at 0xFFFFFFFF at the first byte of a frame. It updates LSB first with the reflected polynomial 0xEDB88320. Enabled bytes enter as received and disabled bytes enter as 0x00. The final value, bitwise inverted, must equal the stored CRC.
- R5: A slot's CRC covers its length rounded up to a multiple of 8 bytes. A length above 128 is treated as 128. Bytes past offset 127 never enter a CRC.
- R6: A frame whose last byte comes before the end of a slot's CRC span does not match that slot.
- R7: A slot with length 0 never matches.
- R8: While the global enable is 0, no match raises wake_o.
- R9: A match is decided on the beat with valid_i and eof_i high. wake_o is high from the clock edge that samples that beat. If several slots match, wake_idx_o carries the lowest matching index.
- R10: Once set, wake_o and wake_idx_o hold through later frames until a write to address 32. That write clears wake_o unless a new match is decided in the same cycle.
- R11: A beat with sof_i high restarts the byte offset and every CRC lane, even in the middle of an unfinished frame. Cycles with valid_i low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Frame byte valid |
| sof_i | input | 1 | First byte of frame (with valid_i) |
| eof_i | input | 1 | Last byte of frame (with valid_i) |
| data_i | input | 8 | Frame byte |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register word address |
| wr_data_i | input | 64 | Register write data |
| wake_o | output | 1 | Sticky wake flag |
| wake_idx_o | output | 3 | Index of lowest matching slot |

## Verification
The wake decision is registered once, on the clock edge that samples the last frame byte. The bench therefore drives each byte on a falling edge and reads wake_o and wake_idx_o on the falling edge right after the last byte. Register writes take effect at the edge after the strobe is driven, so a clear is checked one falling edge later. Checks on holding behaviour and on ignored bytes run a further frame and read the flag at the same point after its last byte.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
  parameter int NUM_PAT   = 8;
  parameter int MAX_BYTES = 128;
  parameter int BE_WORDS  = MAX_BYTES / 8;
  parameter int BE_W      = 8 * NUM_PAT;
  parameter int IDX_W     = $clog2(NUM_PAT);
  parameter int CNT_W     = $clog2(MAX_BYTES) + 1;
  parameter int ADDR_W    = 6;
  parameter logic [31:0] CRC_POLY = 32'hEDB88320;
  parameter int A_LEN  = 16;
  parameter int A_CRC  = 24;
  parameter int A_CTRL = 32;

  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/wkp_cfg_regs.sv
module wkp_cfg_regs import wkp_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [63:0]       wr_data_i,
  output logic [BE_W-1:0]   be_o   [BE_WORDS],
  output logic [CNT_W-1:0]  len_o  [NUM_PAT],
  output logic [31:0]       crc_o  [NUM_PAT],
  output logic              en_o,
  output logic              clr_o
);
  localparam int WA_W = $clog2(BE_WORDS);

  assign clr_o = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < BE_WORDS; w++) be_o[w] <= '0;
      for (int p = 0; p < NUM_PAT; p++) begin
        len_o[p] <= '0;
        crc_o[p] <= '0;
      end
      en_o <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i < ADDR_W'(BE_WORDS))
        be_o[wr_addr_i[WA_W-1:0]] <= wr_data_i[BE_W-1:0];
      else if (wr_addr_i >= ADDR_W'(A_LEN) && wr_addr_i < ADDR_W'(A_LEN + NUM_PAT))
        len_o[wr_addr_i[IDX_W-1:0]] <= wr_data_i[CNT_W-1:0];
      else if (wr_addr_i >= ADDR_W'(A_CRC) && wr_addr_i < ADDR_W'(A_CRC + NUM_PAT))
        crc_o[wr_addr_i[IDX_W-1:0]] <= wr_data_i[31:0];
      else if (clr_o)
        en_o <= wr_data_i[0];
    end
  end
endmodule

// File: rtl/wkp_crc_lane.sv
module wkp_crc_lane import wkp_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [7:0]       data_i,
  input  logic             en_bit_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [31:0]      exp_i,
  output logic             hit_o
);
  logic [31:0]      crc_q, crc_base, crc_nxt;
  logic [CNT_W-1:0] len_eff, len_up, span;
  logic             in_span, done;

  assign len_eff  = (len_i > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : len_i;
  assign len_up   = len_eff + CNT_W'(7);
  assign span     = {len_up[CNT_W-1:3], 3'b000};
  assign in_span  = offset_i < span;
  assign done     = ({1'b0, offset_i} + 1'b1) >= {1'b0, span};
  assign crc_base = sof_i ? 32'hFFFF_FFFF : crc_q;
  assign crc_nxt  = in_span ? crc32_byte(crc_base, en_bit_i ? data_i : 8'h00) : crc_base;
  assign hit_o    = valid_i && eof_i && (len_i != '0) && done && (~crc_nxt == exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= 32'hFFFF_FFFF;
    else if (valid_i) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/wake_crc_matcher.sv
module wake_crc_matcher import wkp_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        sof_i,
  input  logic        eof_i,
  input  logic [7:0]  data_i,
  input  logic        wr_en_i,
  input  logic [5:0]  wr_addr_i,
  input  logic [63:0] wr_data_i,
  output logic        wake_o,
  output logic [2:0]  wake_idx_o
);
  localparam int WA_W = $clog2(BE_WORDS);

  logic [BE_W-1:0]  be   [BE_WORDS];
  logic [CNT_W-1:0] len  [NUM_PAT];
  logic [31:0]      crc  [NUM_PAT];
  logic             en_q, clr;
  logic [CNT_W-1:0] cnt_q, off;
  logic [BE_W-1:0]  be_word;
  logic             in_range;
  logic [NUM_PAT-1:0] hit;
  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;

  wkp_cfg_regs u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .be_o(be), .len_o(len), .crc_o(crc), .en_o(en_q), .clr_o(clr)
  );

  assign off      = sof_i ? '0 : cnt_q;
  assign in_range = off < CNT_W'(MAX_BYTES);
  assign be_word  = in_range ? be[off[WA_W+2:3]] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= in_range ? off + 1'b1 : CNT_W'(MAX_BYTES);
  end

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_lane
    localparam logic [IDX_W-1:0] PI = IDX_W'(p);
    wkp_crc_lane u_lane (
      .clk_i, .rst_ni, .valid_i, .sof_i, .eof_i, .data_i,
      .en_bit_i(be_word[{~off[2:0], PI}]),
      .offset_i(off), .len_i(len[p]), .exp_i(crc[p]),
      .hit_o(hit[p])
    );
  end

  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int p = NUM_PAT - 1; p >= 0; p--) begin
      if (hit[p]) begin
        any_hit = 1'b1;
        hit_idx = IDX_W'(p);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_o     <= 1'b0;
      wake_idx_o <= '0;
    end else if (en_q && any_hit && (!wake_o || clr)) begin
      wake_o     <= 1'b1;
      wake_idx_o <= hit_idx;
    end else if (clr) begin
      wake_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wkp_chk.sv
module wkp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       eof_i,
  input logic       wr_en_i,
  input logic [5:0] wr_addr_i,
  input logic       wake_o,
  input logic [2:0] wake_idx_o,
  input logic       en_i
);
  logic clr;
  assign clr = wr_en_i && (wr_addr_i == 6'd32);

  AST_WAKE_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(valid_i && eof_i)); // R9
  AST_WAKE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(en_i)); // R8
  AST_WAKE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !clr) |=> wake_o); // R10
  AST_IDX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !clr) |=> $stable(wake_idx_o)); // R10
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !(valid_i && eof_i)) |=> !wake_o); // R10
endmodule

bind wake_crc_matcher wkp_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .eof_i(eof_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wake_o(wake_o),
  .wake_idx_o(wake_idx_o), .en_i(en_q)
);

// File: tb/wake_crc_matcher_test.sv
`timescale 1ns/1ps
module wake_crc_matcher_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [7:0] data = 8'h00;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic wake;
  logic [2:0] wake_idx;
  int checks = 0, errors = 0, cyc = 0;
  logic [63:0] be_sh [16];

  always #10 clk = ~clk;

  wake_crc_matcher uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sof_i(sof), .eof_i(eof),
    .data_i(data), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wake_o(wake), .wake_idx_o(wake_idx)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // {slot, plen, flen, corrupt, expect_wake}
  localparam logic [20:0] VEC [7] = '{
    {3'd0, 8'd8,   8'd20,  1'b0, 1'b1},
    {3'd5, 8'd13,  8'd64,  1'b0, 1'b1},
    {3'd7, 8'd128, 8'd128, 1'b0, 1'b1},
    {3'd2, 8'd20,  8'd23,  1'b0, 1'b0},
    {3'd3, 8'd20,  8'd24,  1'b0, 1'b1},
    {3'd1, 8'd16,  8'd30,  1'b1, 1'b0},
    {3'd4, 8'd200, 8'd140, 1'b0, 1'b1}
  };

  function automatic string vtag(int k);
    case (k)
      0: return "R2";
      1: return "R5";
      2: return "R5";
      3: return "R6";
      4: return "R6";
      5: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [7:0] fbyte(int i, int seed);
    return 8'((i * 29 + seed * 71 + 3) & 255);
  endfunction

  function automatic logic [31:0] crc_upd(logic [31:0] c, logic [7:0] d);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_be();
    for (int w = 0; w < 16; w++) wr(w, be_sh[w]);
  endtask

  task automatic clear_cfg();
    for (int w = 0; w < 16; w++) be_sh[w] = '0;
    for (int p = 0; p < 8; p++) wr(16 + p, 0);
    wr(32, 0);
  endtask

  // R3 R4 R5: masked stream, enabled where i%3 != 1, span rounded to 8
  task automatic program_slot(int slot, int plen, int seed, bit corrupt);
    int pe, span;
    logic [31:0] c;
    logic en;
    pe = (plen > 128) ? 128 : plen;
    span = ((pe + 7) / 8) * 8;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < span; i++) begin
      en = (i < pe) && (i % 3 != 1);
      if (en) be_sh[i / 8][(7 - i % 8) * 8 + slot] = 1'b1;
      c = crc_upd(c, en ? fbyte(i, seed) : 8'h00);
    end
    wr(16 + slot, 64'(plen));
    wr(24 + slot, 64'(~c ^ {31'h0, corrupt}));
  endtask

  task automatic send_frame(int flen, int seed, int flip, bit gap, bit term);
    for (int i = 0; i < flen; i++) begin
      if (gap && i == 3) begin
        @(negedge clk);
        valid = 1'b0; sof = 1'b0; eof = 1'b0; data = 8'hA5;
      end
      @(negedge clk);
      valid = 1'b1;
      sof = (i == 0);
      eof = term && (i == flen - 1);
      data = fbyte(i, seed) ^ ((i == flip) ? 8'hFF : 8'h00);
    end
    if (term) begin
      @(negedge clk);
      valid = 1'b0; sof = 1'b0; eof = 1'b0;
    end
  endtask

  initial begin
    for (int w = 0; w < 16; w++) be_sh[w] = '0;
    repeat (3) @(negedge clk);
    check("R1 wake after reset", 32'(wake), 0);
    check("R1 idx after reset", 32'(wake_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    send_frame(16, 0, -1, 1'b0, 1'b1);
    check("R1 no wake with reset config", 32'(wake), 0);

    for (int k = 0; k < 7; k++) begin
      clear_cfg();
      program_slot(int'(VEC[k][20:18]), int'(VEC[k][17:10]), k, VEC[k][1]);
      write_be();
      wr(32, 1);
      send_frame(int'(VEC[k][9:2]), k, -1, 1'b0, 1'b1);
      check(vtag(k), 32'(wake), 32'(VEC[k][0]));
      if (VEC[k][0]) check("R9 vector idx", 32'(wake_idx), 32'(VEC[k][20:18]));
    end

    // R7 zero length, CRC register equal to CRC of empty span
    clear_cfg();
    wr(24, 0);
    write_be();
    wr(32, 1);
    send_frame(16, 0, -1, 1'b0, 1'b1);
    check("R7 zero length slot", 32'(wake), 0);

    // R8 global enable
    clear_cfg();
    program_slot(1, 8, 9, 1'b0);
    write_be();
    send_frame(16, 9, -1, 1'b0, 1'b1);
    check("R8 enable off", 32'(wake), 0);
    wr(32, 1);
    send_frame(16, 9, -1, 1'b0, 1'b1);
    check("R8 enable on", 32'(wake), 1);
    check("R8 enable on idx", 32'(wake_idx), 1);

    // R3 R4 disabled byte ignored, enabled byte counts; R11 gap
    clear_cfg();
    program_slot(6, 16, 2, 1'b0);
    write_be();
    wr(32, 1);
    send_frame(20, 2, 1, 1'b1, 1'b1);
    check("R4 disabled byte ignored", 32'(wake), 1);
    check("R3 idx slot 6", 32'(wake_idx), 6);
    wr(32, 1);
    send_frame(20, 2, 0, 1'b0, 1'b1);
    check("R3 enabled byte 0 counts", 32'(wake), 0);

    // R9 lowest index, R10 sticky and clear
    clear_cfg();
    program_slot(6, 8, 4, 1'b0);
    program_slot(2, 8, 4, 1'b0);
    write_be();
    wr(32, 1);
    send_frame(12, 4, -1, 1'b0, 1'b1);
    check("R9 two matches", 32'(wake), 1);
    check("R9 lowest index", 32'(wake_idx), 2);
    send_frame(12, 4, 0, 1'b0, 1'b1);
    check("R10 sticky wake", 32'(wake), 1);
    check("R10 sticky idx", 32'(wake_idx), 2);
    wr(32, 1);
    check("R10 clear by control write", 32'(wake), 0);

    // R11 restart on sof in an unfinished frame
    send_frame(5, 11, -1, 1'b0, 1'b0);
    send_frame(12, 4, -1, 1'b0, 1'b1);
    check("R11 restart on sof", 32'(wake), 1);
    check("R11 restart idx", 32'(wake_idx), 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule